// File: doc/BRIEF.md
# Two-Channel Triggered DMA Controller

This block moves single bytes through a shared data-memory bus on behalf of two independent channels. Each channel holds a source address, a destination address, a remaining-unit count and an addressing mode. Software sets these up through a simple register port and then enables the channel. After that, every hardware or software trigger on the channel moves exactly one unit: one read from the source, then one write to the destination. The count then drops by one. When the count runs out, the channel raises its completion flag, and the shared interrupt stays high until software has cleared every raised flag.

The memory side is a valid/ready request port. A request, once raised, holds its address, direction and write data unchanged until `mem_ready` is seen high. Read data is taken in the cycle the read is accepted. The CPU has priority on the bus. While `cpu_hold` is high, no new transfer is granted. A channel keeps one pending flag, so triggers that arrive before the grant merge into one transfer. An outside decoder reports through `mem_addr_ok` whether the presented address lies in a real region. The engine issues no bus cycle for an address that is not valid. In that case a read yields zero and a write is dropped.

Top module: `trig_dma`

## Requirements
- R1: A channel accepts triggers only while its enable bit is 1. The enable bits sit in register 0, with bit c for channel c. A trigger on a disabled channel moves nothing and leaves the count unchanged.
- R2: One accepted trigger produces one bus read at the channel's source address, then one bus write of that byte to its destination address. The count register drops by one. The per-channel registers sit at 4+4c: +0 source, +1 destination, +2 count, +3 mode.
- R3: Mode bit 0 set makes the source address step up by one after each unit; mode bit 1 does the same for the destination. A cleared bit keeps that address fixed.
- R4: The unit that takes the count to zero sets the channel's flag (register 1, bit c). The interrupt output is high whenever any flag is set, and it stays high until every flag is cleared.
- R5: Writing 1 to bit c of register 1 clears flag c. Writing 0 leaves it unchanged.
- R6: No transfer is granted while `cpu_hold` is high. A trigger that arrives during that wait stays pending. Further triggers before the grant merge into it, giving one transfer.
- R7: A software trigger (register 2, bit c) in the same cycle as a hardware trigger on the same channel gives one transfer, not two.
- R8: When the source address is not valid, no read is issued and the byte written is 0x00. When the destination address is not valid, no write is issued, but the unit still counts as done.
- R9: When both channels are pending, channel 0 is served first and channel 1 follows.
- R10: While a channel's count is zero, its triggers are ignored. Writing a nonzero count arms the channel again.
- R11: Clearing a channel's enable bit discards a pending transfer that has not yet been granted.
- R12: With no CPU hold and no bus stall, hardware triggers four clocks apart each complete one unit, with none lost.
- R13: While `mem_valid` is high and `mem_ready` is low, the request (address, direction, write data) holds stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for both read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| hw_trig | input | 2 | Hardware trigger pulse per channel |
| cpu_hold | input | 1 | CPU owns the data bus this cycle |
| mem_valid | output | 1 | Bus request valid |
| mem_ready | input | 1 | Bus accepts the request this cycle |
| mem_write | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 16 | Bus address (also drives the region decoder) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the accepting cycle |
| mem_addr_ok | input | 1 | Presented address lies in a valid region |
| irq | output | 1 | Shared completion interrupt |

## Verification
The assertions assume that `mem_addr_ok` is a pure function of `mem_addr`, so it cannot change while a request waits on `mem_ready`. They place no limit on how long `mem_ready` stays low or on when `cpu_hold` is high. The bench's memory model decodes the top address byte 0xFF as invalid and everything else as valid. Its random phase stalls `mem_ready` and pulses `cpu_hold` freely, but it keeps only one trigger outstanding at a time. Under that condition no trigger can merge with another, so the expected sequence of addresses and data is exact.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  localparam int unsigned REG_W = 16;

  // register index layout
  localparam int REG_CTRL   = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_SWTRIG = 2;
  localparam int CH_BASE    = 4;
  localparam int CH_STRIDE  = 4;
  localparam int F_SRC      = 0;
  localparam int F_DST      = 1;
  localparam int F_CNT      = 2;
  localparam int F_MODE     = 3;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } eng_state_e;

  typedef struct packed {
    logic dst_inc;
    logic src_inc;
  } addr_mode_t;

endpackage

// File: rtl/tdma_prio_arb.sv
module tdma_prio_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // lowest index wins; blk[i] is high when any lower index requests
  logic [N-1:0] blk;

  assign blk[0] = 1'b0;
  assign gnt[0] = req[0];

  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign blk[i] = blk[i-1] | req[i-1];
      assign gnt[i] = req[i] & ~blk[i];
    end
  endgenerate

endmodule

// File: rtl/tdma_chan.sv
module tdma_chan
  import tdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_src,
  input  logic              wr_dst,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic              wr_en,
  input  logic              en_val,
  input  logic [REG_W-1:0]  wdata,
  input  logic              sw_trig,
  input  logic              hw_trig,
  input  logic              clr_done,
  input  logic              grant,
  input  logic              step,
  output logic              pend,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  cnt,
  output addr_mode_t        mode,
  output logic              en,
  output logic              done
);

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  addr_mode_t        mode_q;
  logic              en_q, pend_q, done_q;
  logic              en_d, armed, trig, last_step;

  always_comb begin
    en_d      = wr_en ? en_val : en_q;
    armed     = en_q && (cnt_q != '0);
    // a software request takes the slot; a same-cycle hardware pulse adds nothing
    if (sw_trig) trig = armed;
    else         trig = armed && hw_trig;
    last_step = step && (cnt_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      mode_q <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_src)                     src_q <= wdata[ADDR_W-1:0];
      else if (step && mode_q.src_inc) src_q <= src_q + 1'b1;

      if (wr_dst)                     dst_q <= wdata[ADDR_W-1:0];
      else if (step && mode_q.dst_inc) dst_q <= dst_q + 1'b1;

      if (wr_cnt)    cnt_q <= wdata[CNT_W-1:0];
      else if (step) cnt_q <= cnt_q - 1'b1;

      if (wr_mode) mode_q <= addr_mode_t'(wdata[1:0]);

      en_q <= en_d;

      // one pending slot: later triggers overwrite, never queue
      if (!en_d || last_step) pend_q <= 1'b0;
      else if (trig)          pend_q <= 1'b1;
      else if (grant)         pend_q <= 1'b0;

      if (last_step)     done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end

  assign pend = pend_q;
  assign src  = src_q;
  assign dst  = dst_q;
  assign cnt  = cnt_q;
  assign mode = mode_q;
  assign en   = en_q;
  assign done = done_q;

endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
  import tdma_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             pend,
  input  logic [NCH-1:0][ADDR_W-1:0] src_all,
  input  logic [NCH-1:0][ADDR_W-1:0] dst_all,
  input  logic                       cpu_hold,
  output logic [NCH-1:0]             grant,
  output logic [NCH-1:0]             step,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic                       mem_write,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  input  logic                       mem_addr_ok
);

  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  eng_state_e        st_q, st_d;
  logic [CH_W-1:0]   ch_q, win_idx;
  logic [ADDR_W-1:0] sa_q, da_q;
  logic [DATA_W-1:0] buf_q;
  logic [NCH-1:0]    win;
  logic              load, rd_take, finish;

  tdma_prio_arb #(.N(NCH)) u_arb (
    .req (pend),
    .gnt (win)
  );

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (win[i]) win_idx = CH_W'(i);
    end
  end

  always_comb begin
    st_d      = st_q;
    grant     = '0;
    load      = 1'b0;
    rd_take   = 1'b0;
    finish    = 1'b0;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = '0;
    unique case (st_q)
      ENG_IDLE: begin
        if ((|pend) && !cpu_hold) begin
          grant = win;
          load  = 1'b1;
          st_d  = ENG_READ;
        end
      end
      ENG_READ: begin
        mem_addr = sa_q;
        if (!mem_addr_ok) begin
          rd_take = 1'b1;
          st_d    = ENG_WRITE;
        end else begin
          mem_valid = 1'b1;
          if (mem_ready) begin
            rd_take = 1'b1;
            st_d    = ENG_WRITE;
          end
        end
      end
      ENG_WRITE: begin
        mem_addr  = da_q;
        mem_write = 1'b1;
        if (!mem_addr_ok) begin
          finish = 1'b1;
        end else begin
          mem_valid = 1'b1;
          finish    = mem_ready;
        end
        if (finish) st_d = ENG_IDLE;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_step
      assign step[g] = finish && (ch_q == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      ch_q  <= '0;
      sa_q  <= '0;
      da_q  <= '0;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (load) begin
        ch_q <= win_idx;
        sa_q <= src_all[win_idx];
        da_q <= dst_all[win_idx];
      end
      if (rd_take) buf_q <= mem_addr_ok ? mem_rdata : '0;
    end
  end

  assign mem_wdata = buf_q;

endmodule

// File: rtl/trig_dma.sv
module trig_dma
  import tdma_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int REG_AW = $clog2(CH_BASE + CH_STRIDE * NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    hw_trig,
  input  logic              cpu_hold,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_addr_ok,
  output logic              irq
);

  logic [NCH-1:0][ADDR_W-1:0] src_w, dst_w;
  logic [NCH-1:0][CNT_W-1:0]  cnt_w;
  addr_mode_t [NCH-1:0]       mode_w;
  logic [NCH-1:0]             en_w, done_w, pend_w, grant_w, step_w;
  logic                       ctrl_we, stat_we, swt_we;

  assign ctrl_we = reg_we && (reg_addr == REG_AW'(REG_CTRL));
  assign stat_we = reg_we && (reg_addr == REG_AW'(REG_STATUS));
  assign swt_we  = reg_we && (reg_addr == REG_AW'(REG_SWTRIG));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int BASE = CH_BASE + CH_STRIDE * g;
      tdma_chan #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_src   (reg_we && (reg_addr == REG_AW'(BASE + F_SRC))),
        .wr_dst   (reg_we && (reg_addr == REG_AW'(BASE + F_DST))),
        .wr_cnt   (reg_we && (reg_addr == REG_AW'(BASE + F_CNT))),
        .wr_mode  (reg_we && (reg_addr == REG_AW'(BASE + F_MODE))),
        .wr_en    (ctrl_we),
        .en_val   (reg_wdata[g]),
        .wdata    (reg_wdata),
        .sw_trig  (swt_we && reg_wdata[g]),
        .hw_trig  (hw_trig[g]),
        .clr_done (stat_we && reg_wdata[g]),
        .grant    (grant_w[g]),
        .step     (step_w[g]),
        .pend     (pend_w[g]),
        .src      (src_w[g]),
        .dst      (dst_w[g]),
        .cnt      (cnt_w[g]),
        .mode     (mode_w[g]),
        .en       (en_w[g]),
        .done     (done_w[g])
      );
    end
  endgenerate

  tdma_engine #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend_w),
    .src_all     (src_w),
    .dst_all     (dst_w),
    .cpu_hold    (cpu_hold),
    .grant       (grant_w),
    .step        (step_w),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_addr_ok (mem_addr_ok)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(REG_CTRL))   reg_rdata = REG_W'(en_w);
    if (reg_addr == REG_AW'(REG_STATUS)) reg_rdata = REG_W'(done_w);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == REG_AW'(CH_BASE + CH_STRIDE * c + F_SRC))  reg_rdata = REG_W'(src_w[c]);
      if (reg_addr == REG_AW'(CH_BASE + CH_STRIDE * c + F_DST))  reg_rdata = REG_W'(dst_w[c]);
      if (reg_addr == REG_AW'(CH_BASE + CH_STRIDE * c + F_CNT))  reg_rdata = REG_W'(cnt_w[c]);
      if (reg_addr == REG_AW'(CH_BASE + CH_STRIDE * c + F_MODE)) reg_rdata = REG_W'(mode_w[c]);
    end
  end

  assign irq = |done_w;

endmodule

// File: rtl/tdma_checks.sv
module tdma_checks #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_hold,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_addr_ok,
  input logic              irq,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [NCH-1:0]    clr_bits,
  input logic [NCH-1:0]    pend,
  input logic [NCH-1:0]    grant
);

  logic clr_any;
  assign clr_any = reg_we && (reg_addr == REG_AW'(tdma_pkg::REG_STATUS)) && (|clr_bits);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9

  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> !cpu_hold); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata))); // R13

  AST_NO_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> mem_addr_ok); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_any) |=> irq); // R4

  generate
    for (genvar i = 1; i < NCH; i++) begin : g_prio
      AST_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        grant[i] |-> !(|pend[i-1:0])); // R9
    end
  endgenerate

endmodule

bind trig_dma tdma_checks #(
  .NCH    (NCH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .REG_AW (REG_AW)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_hold    (cpu_hold),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_write   (mem_write),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_addr_ok (mem_addr_ok),
  .irq         (irq),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .clr_bits    (reg_wdata[NCH-1:0]),
  .pend        (pend_w),
  .grant       (grant_w)
);

// File: tb/test_trig_dma.sv
module test_trig_dma;

  localparam int RCTRL = 0, RSTAT = 1, RSWT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  hw_trig = '0;
  logic        cpu_hold = 1'b0;
  logic        mem_valid, mem_ready, mem_write, mem_addr_ok, irq;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  trig_dma i_trig_dma (
    .clk (clk), .rst_n (rst_n), .reg_we (reg_we), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .hw_trig (hw_trig),
    .cpu_hold (cpu_hold), .mem_valid (mem_valid), .mem_ready (mem_ready),
    .mem_write (mem_write), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata), .mem_addr_ok (mem_addr_ok), .irq (irq)
  );

  // memory model: top byte 0xFF is an invalid region
  logic [7:0] mem [256];
  logic       rdy = 1'b1;
  int         stall_mode = 0, hold_mode = 0;
  logic       hold_force = 1'b0;
  int         wcnt = 0, rcnt = 0;
  logic [15:0] wa [512];
  logic [7:0]  wd [512];
  int n_chk = 0, n_fail = 0;

  assign mem_addr_ok = (mem_addr[15:8] != 8'hFF);
  assign mem_rdata   = mem_addr_ok ? mem[mem_addr[7:0]] : 8'hA5;
  assign mem_ready   = rdy;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 11);
  endfunction

  function automatic int exp_addr(int base, bit inc, int k);
    return inc ? base + k : base;
  endfunction

  always @(negedge clk) begin
    case (stall_mode)
      0:       rdy = 1'b1;
      1:       rdy = 1'b0;
      default: rdy = ($urandom_range(2) != 0);
    endcase
    cpu_hold = (hold_mode == 2) ? ($urandom_range(3) == 0) : hold_force;
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr[7:0]] = mem_wdata;
        wa[wcnt % 512] = mem_addr;
        wd[wcnt % 512] = mem_wdata;
        wcnt++;
      end else begin
        rcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[3:0]; reg_wdata = d[15:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input int a, output int d);
    @(negedge clk);
    reg_addr = a[3:0];
    #2;
    d = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic hw(input logic [1:0] m);
    @(negedge clk); hw_trig = m;
    @(negedge clk); hw_trig = '0;
  endtask

  task automatic cfg(input int c, input int s, input int d, input int n, input int m);
    wreg(4 + 4 * c, s);
    wreg(5 + 4 * c, d);
    wreg(6 + 4 * c, n);
    wreg(7 + 4 * c, m);
  endtask

  task automatic wait_writes(input int target);
    int guard = 0;
    while (wcnt < target && guard < 400) begin
      @(negedge clk); #3;
      guard++;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", wcnt, 0);
    finish_run();
  end

  initial begin
    int v, w0, r0;
    void'($urandom(32'd7741));
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rreg(RCTRL, v); chk(v == 0, "R1 reset enables", v, 0);
    rreg(RSTAT, v); chk(v == 0, "R4 reset flags", v, 0);
    chk(irq == 1'b0, "R4 reset irq", irq, 0);
    chk(mem_valid == 1'b0, "R13 reset idle bus", mem_valid, 0);

    // R1: disabled channel ignores triggers
    cfg(0, 'h10, 'h80, 2, 1);
    w0 = wcnt;
    hw(2'b01); idle(10);
    chk(wcnt == w0, "R1 no write while disabled", wcnt, w0);
    rreg(6, v); chk(v == 2, "R1 count untouched", v, 2);

    // R2/R3: src increments, dst fixed
    wreg(RCTRL, 1);
    hw(2'b01); idle(10);
    chk(wcnt == w0 + 1, "R2 one write", wcnt, w0 + 1);
    chk(wa[w0 % 512] == 16'h0080, "R2 dst addr", wa[w0 % 512], 'h80);
    chk(wd[w0 % 512] == pat('h10), "R2 data", wd[w0 % 512], pat('h10));
    rreg(6, v); chk(v == 1, "R2 count step", v, 1);
    hw(2'b01); idle(10);
    chk(wa[(w0 + 1) % 512] == 16'h0080, "R3 dst fixed", wa[(w0 + 1) % 512], 'h80);
    chk(wd[(w0 + 1) % 512] == pat('h11), "R3 src increments", wd[(w0 + 1) % 512], pat('h11));
    rreg(RSTAT, v); chk(v == 1, "R4 flag set at zero", v, 1);
    chk(irq == 1'b1, "R4 irq raised", irq, 1);

    // R10: count zero ignores, rearm by writing count
    w0 = wcnt;
    hw(2'b01); idle(10);
    chk(wcnt == w0, "R10 ignored at zero", wcnt, w0);
    wreg(6, 1); hw(2'b01); idle(10);
    chk(wcnt == w0 + 1, "R10 rearmed", wcnt, w0 + 1);
    chk(wd[w0 % 512] == pat('h12), "R10 continues source", wd[w0 % 512], pat('h12));

    // R5: write-one-to-clear
    wreg(RSTAT, 0); rreg(RSTAT, v); chk(v == 1, "R5 zero write no effect", v, 1);
    wreg(RSTAT, 1); rreg(RSTAT, v); chk(v == 0, "R5 cleared", v, 0);
    chk(irq == 1'b0, "R5 irq dropped", irq, 0);

    // R12 with R3 dst increment, src fixed: triggers four clocks apart
    cfg(1, 'h20, 'h90, 3, 2);
    wreg(RCTRL, 3);
    w0 = wcnt;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); hw_trig = 2'b10;
      @(negedge clk); hw_trig = 2'b00;
      repeat (2) @(negedge clk);
    end
    idle(12);
    chk(wcnt == w0 + 3, "R12 no trigger lost", wcnt, w0 + 3);
    for (int k = 0; k < 3; k++) begin
      chk(wa[(w0 + k) % 512] == 16'(16'h90 + k), "R3 dst increments", wa[(w0 + k) % 512], 'h90 + k);
      chk(wd[(w0 + k) % 512] == pat('h20), "R3 src fixed", wd[(w0 + k) % 512], pat('h20));
    end
    rreg(RSTAT, v); chk(v == 2, "R4 channel 1 flag", v, 2);

    // R4: irq is OR of flags
    cfg(0, 'h30, 'hA0, 1, 0);
    hw(2'b01); idle(10);
    rreg(RSTAT, v); chk(v == 3, "R4 both flags", v, 3);
    wreg(RSTAT, 2); chk(irq == 1'b1, "R4 irq held by other flag", irq, 1);
    wreg(RSTAT, 1); chk(irq == 1'b0, "R4 irq low when all clear", irq, 0);

    // R9: simultaneous triggers, channel 0 first
    cfg(0, 'h31, 'hB0, 1, 0);
    cfg(1, 'h32, 'hB8, 1, 0);
    w0 = wcnt;
    hw(2'b11); idle(14);
    chk(wcnt == w0 + 2, "R9 both served", wcnt, w0 + 2);
    chk(wa[w0 % 512] == 16'h00B0, "R9 channel 0 first", wa[w0 % 512], 'hB0);
    chk(wa[(w0 + 1) % 512] == 16'h00B8, "R9 channel 1 second", wa[(w0 + 1) % 512], 'hB8);
    wreg(RSTAT, 3);

    // R6: CPU hold blocks grant; triggers merge
    cfg(0, 'h40, 'hC0, 3, 1);
    w0 = wcnt;
    hold_force = 1'b1;
    hw(2'b01); idle(2); hw(2'b01); idle(8);
    chk(wcnt == w0, "R6 held off by CPU", wcnt, w0);
    hold_force = 1'b0;
    idle(10);
    chk(wcnt == w0 + 1, "R6 merged to one", wcnt, w0 + 1);
    rreg(6, v); chk(v == 2, "R6 one count step", v, 2);

    // R7: hardware and software trigger in one cycle
    w0 = wcnt;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(RSWT); reg_wdata = 16'h0001; hw_trig = 2'b01;
    @(negedge clk);
    reg_we = 1'b0; hw_trig = 2'b00;
    idle(10);
    chk(wcnt == w0 + 1, "R7 single transfer", wcnt, w0 + 1);
    rreg(6, v); chk(v == 1, "R7 count", v, 1);

    // R8: invalid source yields zero, no read issued
    wreg(4, 'hFF10);
    w0 = wcnt; r0 = rcnt;
    hw(2'b01); idle(10);
    chk(wcnt == w0 + 1, "R8 write done", wcnt, w0 + 1);
    chk(wd[w0 % 512] == 8'h00, "R8 zero data", wd[w0 % 512], 0);
    chk(rcnt == r0, "R8 no read issued", rcnt, r0);
    // R8: invalid destination dropped, unit still counted
    cfg(0, 'h41, 'hFF20, 2, 0);
    w0 = wcnt;
    hw(2'b01); idle(10);
    chk(wcnt == w0, "R8 write dropped", wcnt, w0);
    rreg(6, v); chk(v == 1, "R8 count still steps", v, 1);

    // R11: disabling aborts a pending transfer
    wreg(5, 'hE0);
    hold_force = 1'b1;
    hw(2'b01); idle(2);
    wreg(RCTRL, 2); wreg(RCTRL, 3);
    hold_force = 1'b0;
    idle(10);
    chk(wcnt == w0, "R11 pending discarded", wcnt, w0);
    rreg(6, v); chk(v == 1, "R11 count kept", v, 1);
    wreg(RSTAT, 3);

    // R13: request held under back-pressure
    cfg(0, 'h50, 'hD0, 1, 0);
    w0 = wcnt;
    stall_mode = 1;
    hw(2'b01); idle(6);
    chk(mem_valid && !mem_write && mem_addr == 16'h0050, "R13 read held", int'(mem_addr), 'h50);
    idle(3);
    chk(mem_valid && mem_addr == 16'h0050, "R13 still held", int'(mem_addr), 'h50);
    stall_mode = 0;
    idle(10);
    chk(wcnt == w0 + 1, "R13 completes after release", wcnt, w0 + 1);
    chk(wd[w0 % 512] == pat('h50), "R13 data", wd[w0 % 512], pat('h50));
    wreg(RSTAT, 3);

    // random phase: stalls and CPU holds, one trigger outstanding
    stall_mode = 2; hold_mode = 2;
    for (int it = 0; it < 24; it++) begin
      int c, m, n, s, d;
      c = $urandom_range(1);
      m = $urandom_range(3);
      n = $urandom_range(4, 1);
      s = $urandom_range('h70);
      d = 'h80 + $urandom_range('h70);
      cfg(c, s, d, n, m);
      w0 = wcnt;
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(1) == 0) hw(2'(1 << c));
        else                        wreg(RSWT, 1 << c);
        wait_writes(w0 + k + 1);
        chk(wa[(w0 + k) % 512] == 16'(exp_addr(d, m[1], k)), "R3 random dst",
            wa[(w0 + k) % 512], exp_addr(d, m[1], k));
        chk(wd[(w0 + k) % 512] == pat(exp_addr(s, m[0], k)), "R2 random data",
            wd[(w0 + k) % 512], pat(exp_addr(s, m[0], k)));
      end
      rreg(6 + 4 * c, v); chk(v == 0, "R4 random count exhausted", v, 0);
      wreg(RSTAT, 3);
    end
    stall_mode = 0; hold_mode = 0;
    idle(4);

    finish_run();
  end

endmodule